// File: doc/BRIEF.md
# Serial Port FIFO Status and Interrupt Unit

This block sits beside the transmit and receive FIFOs of a serial port and turns their fill levels and data-movement strobes into status flags and four interrupt sources. Two sources follow FIFO fill thresholds. The transmit source is active while the transmit FIFO is at half depth or below. The receive source is active while the receive FIFO is at half depth or above. The other two sources are sticky events. A receive timeout is flagged when received data has sat unread for a fixed number of serial bit periods. A receive overrun is flagged when a word arrives at a full receive FIFO. The FIFO drops that word, and the flag stays set until software clears it.

Every source can be read in two forms: the raw state before masking, and the masked state. The masked state is the raw state ANDed with a software mask bit. One output line per source carries the masked state, and a further line carries the OR of all four. A small write port gives software two actions. A write to the mask selector loads the mask. A write to the clear selector drops the sticky sources whose data bits are 1. The FIFO storage and the serial shifter are outside this block. They supply the levels, strobes, bit tick and busy indication.

Top module: `sport_irq_status`

## Requirements
- R1: After reset the status vector is 5'b00011 (only TX not full and TX empty set), the raw vector is 4'b1000 (only the transmit source), and every mask bit is 0, so the masked vector and all interrupt lines are 0.
- R2: Status bit 3 (RX full) is 1 exactly when rx_level equals DEPTH. Bit 2 (RX not empty) is 1 when rx_level is nonzero. Bit 1 (TX not full) is 1 when tx_level is below DEPTH. Bit 0 (TX empty) is 1 when tx_level is zero. All four follow the levels in the same cycle.
- R3: Status bit 4 (busy) is 1 whenever shifter_busy is 1 or tx_level is nonzero, and is 0 otherwise.
- R4: Raw bit 3 (transmit source) is 1 exactly when tx_level is at most DEPTH/2, in the same cycle.
- R5: Raw bit 2 (receive source) is 1 exactly when rx_level is at least DEPTH/2, in the same cycle.
- R6: A write with reg_addr=0 loads reg_wdata into the mask on the next clock edge. The mask bit positions are the same as the raw positions. From then on, the masked vector equals raw AND mask.
- R7: Raw bit 1 (receive timeout) sets on the clock edge that takes in the TIMEOUT_BITS-th bit_tick since the last rx_push, the last rx_pop, or the receive FIFO last being empty. A push or pop restarts this count, and the count is held at zero while rx_level is 0.
- R8: A write with reg_addr=1 clears raw bit 1 when reg_wdata[1] is 1, and clears raw bit 0 when reg_wdata[0] is 1. A data bit of 0 leaves that source unchanged. If a set event and a clear arrive in the same cycle, the source stays set.
- R9: Raw bit 0 (receive overrun) sets on the clock edge after an rx_push seen while rx_level equals DEPTH. A push at any lower level does not set it. Once set, it stays set after the FIFO drains, until it is cleared as in R8.
- R10: irq_tx, irq_rx, irq_timeout and irq_overrun equal masked bits 3, 2, 1 and 0. irq_any is 1 exactly when any masked bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_level | input | LW | Words held in the transmit FIFO (0..DEPTH) |
| rx_level | input | LW | Words held in the receive FIFO (0..DEPTH) |
| rx_push | input | 1 | One-cycle strobe: a received word is offered to the receive FIFO |
| rx_pop | input | 1 | One-cycle strobe: a word is read out of the receive FIFO |
| bit_tick | input | 1 | One-cycle strobe per serial bit period |
| shifter_busy | input | 1 | Serial shifter is moving a frame |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Write target: 0 mask, 1 clear |
| reg_wdata | input | 4 | Write data, bit positions as in the raw vector |
| stat | output | 5 | {busy, rx_full, rx_not_empty, tx_not_full, tx_empty} |
| raw | output | 4 | Raw states {tx, rx, timeout, overrun} |
| masked | output | 4 | Masked states, same positions |
| irq_tx | output | 1 | Masked transmit source |
| irq_rx | output | 1 | Masked receive source |
| irq_timeout | output | 1 | Masked receive timeout source |
| irq_overrun | output | 1 | Masked receive overrun source |
| irq_any | output | 1 | OR of all masked sources |

## Verification
The status flags and the two threshold sources are swept over every pair of transmit and receive levels from 0 to DEPTH, with the shifter both busy and idle. This shows whether each threshold and the full/empty boundaries sit on the right level, and whether busy follows the shifter and the transmit level on their own. All sixteen mask values are applied twice: once with every source raised, and once with only the sticky sources raised. This separates a fault in a single mask lane from a fault in the combining OR. For the timeout, the tick count is run to one below the limit and then to the limit, and the count is restarted by a push and by a pop. A long run of ticks is also given with the FIFO empty. For the overrun, pushes are made one below full and at full, the FIFO is drained, and clears are written with the other bit, with the right bit, and in the same cycle as a new overrun.

// File: rtl/sport_pkg.sv
package sport_pkg;
   // positions inside the raw / masked / mask vectors
   localparam int SRC_OV = 0;
   localparam int SRC_TO = 1;
   localparam int SRC_RX = 2;
   localparam int SRC_TX = 3;
   localparam int N_SRC  = 4;
   localparam int N_STICKY = 2;

   // positions inside the status vector
   localparam int ST_TXE  = 0;
   localparam int ST_TXNF = 1;
   localparam int ST_RXNE = 2;
   localparam int ST_RXF  = 3;
   localparam int ST_BSY  = 4;
   localparam int N_STAT  = 5;

   typedef enum logic {
      SEL_MASK  = 1'b0,
      SEL_CLEAR = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/sport_lvl_flags.sv
module sport_lvl_flags
   import sport_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int LW    = $clog2(DEPTH + 1)
) (
   input  logic [LW-1:0]     tx_level,
   input  logic [LW-1:0]     rx_level,
   input  logic              shifter_busy,
   output logic [N_STAT-1:0] stat,
   output logic              tx_thr,
   output logic              rx_thr
);
   localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
   localparam logic [LW-1:0] HALF_LVL = LW'(DEPTH / 2);

   always_comb begin
      stat          = '0;
      stat[ST_TXE]  = (tx_level == '0);
      stat[ST_TXNF] = (tx_level < FULL_LVL);
      stat[ST_RXNE] = (rx_level != '0);
      stat[ST_RXF]  = (rx_level == FULL_LVL);
      stat[ST_BSY]  = shifter_busy | (tx_level != '0);
   end

   assign tx_thr = (tx_level <= HALF_LVL);
   assign rx_thr = (rx_level >= HALF_LVL);
endmodule

// File: rtl/sport_rx_timer.sv
module sport_rx_timer #(
   parameter int TIMEOUT_BITS = 32,
   parameter int CW           = $clog2(TIMEOUT_BITS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_empty,
   input  logic rx_push,
   input  logic rx_pop,
   input  logic bit_tick,
   output logic expire
);
   localparam logic [CW-1:0] LAST = CW'(TIMEOUT_BITS - 1);

   logic [CW-1:0] cnt_q;
   logic          restart;

   assign restart = rx_empty | rx_push | rx_pop;
   assign expire  = bit_tick & ~restart & (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (bit_tick) begin
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/sport_sticky_bit.sv
module sport_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ev,
   input  logic clr_ev,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= 1'b0;
      else if (set_ev)  q <= 1'b1;
      else if (clr_ev)  q <= 1'b0;
   end
endmodule

// File: rtl/sport_irq_mask.sv
module sport_irq_mask #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [N-1:0] wdata,
   input  logic [N-1:0] raw,
   output logic [N-1:0] masked
);
   logic [N-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mask_q <= '0;
      else if (load) mask_q <= wdata;
   end

   for (genvar i = 0; i < N; i++) begin : g_lane
      assign masked[i] = raw[i] & mask_q[i];
   end
endmodule

// File: rtl/sport_irq_status.sv
module sport_irq_status
   import sport_pkg::*;
#(
   parameter int DEPTH        = 8,
   parameter int TIMEOUT_BITS = 32,
   parameter int LW           = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LW-1:0]     tx_level,
   input  logic [LW-1:0]     rx_level,
   input  logic              rx_push,
   input  logic              rx_pop,
   input  logic              bit_tick,
   input  logic              shifter_busy,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [N_SRC-1:0]  reg_wdata,
   output logic [N_STAT-1:0] stat,
   output logic [N_SRC-1:0]  raw,
   output logic [N_SRC-1:0]  masked,
   output logic              irq_tx,
   output logic              irq_rx,
   output logic              irq_timeout,
   output logic              irq_overrun,
   output logic              irq_any
);
   // elaboration-time parameter checks
   if (DEPTH < 2 || (DEPTH % 2) != 0) begin : g_bad_depth
      $error("sport_irq_status: DEPTH must be even and at least 2");
   end
   if (TIMEOUT_BITS < 2) begin : g_bad_to
      $error("sport_irq_status: TIMEOUT_BITS must be at least 2");
   end
   if (LW < $clog2(DEPTH + 1)) begin : g_bad_lw
      $error("sport_irq_status: LW too narrow for DEPTH");
   end

   logic                tx_thr, rx_thr;
   logic                to_expire;
   logic [N_STICKY-1:0] st_set, st_clr, st_q;
   logic                clr_wr, mask_wr;

   assign mask_wr = reg_wr & (reg_sel_e'(reg_addr) == SEL_MASK);
   assign clr_wr  = reg_wr & (reg_sel_e'(reg_addr) == SEL_CLEAR);

   sport_lvl_flags #(.DEPTH(DEPTH), .LW(LW)) u_lvl (
      .tx_level     (tx_level),
      .rx_level     (rx_level),
      .shifter_busy (shifter_busy),
      .stat         (stat),
      .tx_thr       (tx_thr),
      .rx_thr       (rx_thr)
   );

   sport_rx_timer #(.TIMEOUT_BITS(TIMEOUT_BITS)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_empty (~stat[ST_RXNE]),
      .rx_push  (rx_push),
      .rx_pop   (rx_pop),
      .bit_tick (bit_tick),
      .expire   (to_expire)
   );

   // sticky sources occupy raw positions 0 (overrun) and 1 (timeout)
   assign st_set[SRC_OV] = rx_push & stat[ST_RXF];
   assign st_set[SRC_TO] = to_expire;

   for (genvar s = 0; s < N_STICKY; s++) begin : g_sticky
      assign st_clr[s] = clr_wr & reg_wdata[s];
      sport_sticky_bit u_bit (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_ev (st_set[s]),
         .clr_ev (st_clr[s]),
         .q      (st_q[s])
      );
   end

   assign raw = {tx_thr, rx_thr, st_q[SRC_TO], st_q[SRC_OV]};

   sport_irq_mask #(.N(N_SRC)) u_msk (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (mask_wr),
      .wdata  (reg_wdata),
      .raw    (raw),
      .masked (masked)
   );

   assign irq_tx      = masked[SRC_TX];
   assign irq_rx      = masked[SRC_RX];
   assign irq_timeout = masked[SRC_TO];
   assign irq_overrun = masked[SRC_OV];
   assign irq_any     = |masked;
endmodule

// File: rtl/sport_irq_status_chk.sv
module sport_irq_status_chk #(
   parameter int DEPTH = 8,
   parameter int LW    = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [LW-1:0] tx_level,
   input logic [LW-1:0] rx_level,
   input logic          rx_push,
   input logic          rx_pop,
   input logic          shifter_busy,
   input logic          reg_wr,
   input logic          reg_addr,
   input logic [3:0]    reg_wdata,
   input logic [4:0]    stat,
   input logic [3:0]    raw,
   input logic [3:0]    masked,
   input logic          irq_any
);
   localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

   a_r9_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && rx_level == FULL_LVL) |=> raw[0]);

   a_r9_overrun_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (raw[0] && !(reg_wr && reg_addr && reg_wdata[0])) |=> raw[0]);

   a_r8_overrun_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr && reg_wdata[0] && !(rx_push && rx_level == FULL_LVL))
      |=> !raw[0]);

   a_r8_timeout_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (raw[1] && reg_wr && reg_addr && !reg_wdata[1]) |=> raw[1]);

   a_r7_timeout_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw[1]) |-> ($past(rx_level) != '0 && !$past(rx_push) && !$past(rx_pop)));

   a_r6_masked_subset: assert property (@(posedge clk) disable iff (!rst_n)
      (masked & ~raw) == 4'b0000);

   a_r10_any_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      irq_any == ($countones(masked) != 0));

   a_r3_busy_tx: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level != '0 || shifter_busy) |-> stat[4]);
endmodule

bind sport_irq_status sport_irq_status_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tx_level     (tx_level),
   .rx_level     (rx_level),
   .rx_push      (rx_push),
   .rx_pop       (rx_pop),
   .shifter_busy (shifter_busy),
   .reg_wr       (reg_wr),
   .reg_addr     (reg_addr),
   .reg_wdata    (reg_wdata),
   .stat         (stat),
   .raw          (raw),
   .masked       (masked),
   .irq_any      (irq_any)
);

// File: tb/sim_sport_irq_status.sv
module sim_sport_irq_status;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 8;
   localparam int TOB        = 32;
   localparam int LW         = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [LW-1:0] tx_level = '0;
   logic [LW-1:0] rx_level = '0;
   logic          rx_push = 1'b0, rx_pop = 1'b0, bit_tick = 1'b0;
   logic          shifter_busy = 1'b0;
   logic          reg_wr = 1'b0, reg_addr = 1'b0;
   logic [3:0]    reg_wdata = '0;
   logic [4:0]    stat;
   logic [3:0]    raw, masked;
   logic          irq_tx, irq_rx, irq_timeout, irq_overrun, irq_any;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sport_irq_status #(.DEPTH(DEPTH), .TIMEOUT_BITS(TOB)) u0 (
      .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .rx_level(rx_level),
      .rx_push(rx_push), .rx_pop(rx_pop), .bit_tick(bit_tick),
      .shifter_busy(shifter_busy), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .stat(stat), .raw(raw), .masked(masked),
      .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_timeout(irq_timeout),
      .irq_overrun(irq_overrun), .irq_any(irq_any)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) bit_tick = 1'b1;
         @(negedge clk) bit_tick = 1'b0;
      end
   endtask

   task automatic wr(input logic a, input logic [3:0] d);
      @(negedge clk) begin reg_wr = 1'b1; reg_addr = a; reg_wdata = d; end
      @(negedge clk) reg_wr = 1'b0;
   endtask

   task automatic push1();
      @(negedge clk) rx_push = 1'b1;
      @(negedge clk) rx_push = 1'b0;
   endtask

   task automatic pop1();
      @(negedge clk) rx_pop = 1'b1;
      @(negedge clk) rx_pop = 1'b0;
   endtask

   task automatic set_rx(input int lvl);
      @(negedge clk) rx_level = LW'(lvl);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 stat", 32'(stat), 32'h03);
      check("R1 raw", 32'(raw), 32'h8);
      check("R1 masked", 32'(masked), 32'h0);
      check("R1 irq_any", 32'(irq_any), 32'h0);

      // R2 R3 R4 R5 sweep of levels and shifter state
      for (int sb = 0; sb < 2; sb++) begin
         for (int t = 0; t <= DEPTH; t++) begin
            for (int r = 0; r <= DEPTH; r++) begin
               @(negedge clk) begin
                  tx_level = LW'(t); rx_level = LW'(r); shifter_busy = sb[0];
               end
               #1;
               check("R2 status levels", 32'(stat[3:0]),
                     {28'd0, r == DEPTH, r != 0, t < DEPTH, t == 0});
               check("R3 busy", 32'(stat[4]), 32'((t != 0) || (sb != 0)));
               check("R4 tx source", 32'(raw[3]), 32'(t <= DEPTH / 2));
               check("R5 rx source", 32'(raw[2]), 32'(r >= DEPTH / 2));
            end
         end
      end
      @(negedge clk) begin tx_level = '0; rx_level = '0; shifter_busy = 1'b0; end

      // R7 timeout at exactly TOB ticks
      set_rx(3);
      ticks(TOB - 1);
      check("R7 timeout one tick short", 32'(raw[1]), 32'h0);
      ticks(1);
      check("R7 timeout at limit", 32'(raw[1]), 32'h1);
      // R8 write of zero keeps, one clears
      wr(1'b1, 4'b0000);
      check("R8 clear zero no effect", 32'(raw[1]), 32'h1);
      wr(1'b1, 4'b0010);
      check("R8 clear timeout", 32'(raw[1]), 32'h0);
      // R7 push restarts
      ticks(20);
      push1();
      ticks(TOB - 1);
      check("R7 push restart short", 32'(raw[1]), 32'h0);
      ticks(1);
      check("R7 push restart limit", 32'(raw[1]), 32'h1);
      wr(1'b1, 4'b0010);
      // R7 pop restarts
      set_rx(2);
      ticks(TOB - 1);
      pop1();
      ticks(TOB - 1);
      check("R7 pop restart short", 32'(raw[1]), 32'h0);
      ticks(1);
      check("R7 pop restart limit", 32'(raw[1]), 32'h1);
      wr(1'b1, 4'b0010);
      // R7 empty FIFO holds counter
      set_rx(0);
      ticks(TOB + 8);
      check("R7 empty no timeout", 32'(raw[1]), 32'h0);

      // R9 overrun
      set_rx(DEPTH - 1);
      push1();
      check("R9 push below full", 32'(raw[0]), 32'h0);
      set_rx(DEPTH);
      push1();
      check("R9 push at full", 32'(raw[0]), 32'h1);
      set_rx(0);
      repeat (5) @(negedge clk);
      check("R9 sticky after drain", 32'(raw[0]), 32'h1);
      wr(1'b1, 4'b0010);
      check("R8 other clear bit keeps overrun", 32'(raw[0]), 32'h1);
      wr(1'b1, 4'b0001);
      check("R8 clear overrun", 32'(raw[0]), 32'h0);
      // R8 set wins over clear in the same cycle
      set_rx(DEPTH);
      @(negedge clk) begin
         rx_push = 1'b1; reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 4'b0001;
      end
      @(negedge clk) begin rx_push = 1'b0; reg_wr = 1'b0; end
      check("R8 set wins over clear", 32'(raw[0]), 32'h1);

      // R6 R10 mask sweep with every source raised
      set_rx(DEPTH - 2);
      ticks(TOB);
      @(negedge clk) begin tx_level = '0; rx_level = LW'(DEPTH); end
      #1;
      check("R6 all raw set", 32'(raw), 32'hF);
      for (int m = 0; m < 16; m++) begin
         wr(1'b0, 4'(m));
         check("R6 masked all raw", 32'(masked), 32'(m));
         check("R10 irq lines", {28'd0, irq_tx, irq_rx, irq_timeout, irq_overrun}, 32'(m));
         check("R10 irq_any", 32'(irq_any), 32'(m != 0));
      end
      // R6 R10 with only sticky sources raised
      @(negedge clk) begin tx_level = LW'(DEPTH); rx_level = '0; end
      #1;
      for (int m = 0; m < 16; m++) begin
         wr(1'b0, 4'(m));
         check("R6 masked sticky only", 32'(masked), 32'(m & 3));
         check("R10 irq_any sticky only", 32'(irq_any), 32'((m & 3) != 0));
      end
      wr(1'b1, 4'b0011);
      check("R8 clear both", 32'(raw[1:0]), 32'h0);
      check("R10 irq_any after clear", 32'(irq_any), 32'h0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule